// File: doc/BRIEF.md
# Segmented Message Playback Controller

This controller sits beside a free-running voice sequencer that reads playback memory through a 15-bit byte address. It splits a larger memory into equal message segments of 32K bytes each. It drives the segment number as the upper address bits above the sequencer's own address. It starts a message by pulsing the sequencer's active-low play input. The sequencer never halts by itself, so the controller watches the sequencer's most significant address bit. When that bit falls, the address has wrapped past the end of the segment. The controller then holds the sequencer in reset for a few cycles and returns to idle.

The segment is chosen in one of two ways. In sequential mode, each trigger plays the segment after the last one played. The first trigger after reset plays segment 0, and after the top segment the count wraps to segment 0. In host mode, a message number presented with the trigger is latched and played. The sequencer's address bit is assumed to be synchronous to the controller clock.

Top module: `msg_seg_ctrl`

## Requirements
- R1: After reset, and after a reset that cuts a message short, `seg_addr` is 0, `play_n` is 1, `seq_reset` is 0 and `busy` is 0, and the next sequential trigger plays segment 0.
- R2: With `host_mode` at 0, a trigger accepted in idle plays segment 0 if it is the first since reset, and otherwise plays the segment one above the previous message.
- R3: In sequential mode the segment after the top one (2**SEG_W-1) is segment 0.
- R4: With `host_mode` at 1, a trigger accepted in idle latches `host_sel` into `seg_addr`, and a later sequential trigger continues from that value plus one.
- R5: `seg_addr` takes its new value in the cycle after the trigger edge and holds it while `busy` is high and through the following idle time.
- R6: `play_n` is 0 for exactly one cycle per message, the second cycle after the clock edge that accepts the trigger, and is 1 at all other times.
- R7: While a message runs, a cycle with `seq_a14` high followed by a cycle with it low makes `seq_reset` go high from the next cycle for exactly HOLD cycles. The controller then goes idle.
- R8: `busy` is high from the cycle after the accepting edge through the last `seq_reset` cycle, and low in the cycle after that.
- R9: A trigger raised while `busy` is high has no effect: `seg_addr` does not change, no extra play pulse appears, and the sequential count does not advance.
- R10: A falling `seq_a14` while idle produces neither `seq_reset` nor `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_mode | input | 1 | 1 selects host mode, 0 selects sequential mode, sampled with the trigger |
| host_sel | input | SEG_W | Message number for host mode |
| start | input | 1 | Trigger, sampled at each clock edge while idle |
| seq_a14 | input | 1 | Top address bit of the sequencer |
| seg_addr | output | SEG_W | Upper memory address bits (segment number) |
| play_n | output | 1 | Play pulse to the sequencer, active low |
| seq_reset | output | 1 | Reset to the sequencer, active high |
| busy | output | 1 | High while a message is being set up, played or stopped |

## Verification
The bench builds the controller with SEG_W at its default of 5, which gives 32 segments, and with HOLD set to 3. A stop longer than two cycles therefore exposes a count that ends early or late. With 32 segments, a host jump to segment 30 followed by sequential triggers reaches the wrap from 31 to 0 in a few messages. Host selections and sequential steps are mixed, so the sequential count is also checked after it has been seeded by a host selection.

// File: rtl/msg_seg_ctrl.sv
module msg_seg_ctrl #(
  parameter int SEG_W = 5,
  parameter int HOLD  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_mode,
  input  logic [SEG_W-1:0] host_sel,
  input  logic             start,
  input  logic             seq_a14,
  output logic [SEG_W-1:0] seg_addr,
  output logic             play_n,
  output logic             seq_reset,
  output logic             busy
);
  localparam int CNT_W = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD - 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_PULSE, S_RUN, S_STOP} st_t;

  st_t              state;
  logic [CNT_W-1:0] cnt;
  logic             a14_q;
  logic             fresh;
  logic             a14_fall;

  assign a14_fall  = a14_q & ~seq_a14;
  assign play_n    = (state != S_PULSE);
  assign seq_reset = (state == S_STOP);
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      seg_addr <= '0;
      cnt      <= '0;
      a14_q    <= 1'b0;
      fresh    <= 1'b1;
    end else begin
      a14_q <= seq_a14;
      case (state)
        S_IDLE:
          if (start) begin
            state <= S_SETUP;
            fresh <= 1'b0;
            if (host_mode)  seg_addr <= host_sel;
            else if (fresh) seg_addr <= '0;
            else            seg_addr <= seg_addr + SEG_W'(1);
          end
        S_SETUP: state <= S_PULSE;
        S_PULSE: state <= S_RUN;
        S_RUN:
          if (a14_fall) begin
            state <= S_STOP;
            cnt   <= '0;
          end
        S_STOP:
          if (cnt == CNT_LAST) state <= S_IDLE;
          else                 cnt   <= cnt + CNT_W'(1);
        default: state <= S_IDLE;
      endcase
    end
  end

  p_play_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !play_n |=> play_n);

  p_play_when_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !play_n |-> busy);

  p_seg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (seg_addr == $past(seg_addr)));

  p_ignore_trig_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(seg_addr));

  p_stop_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && a14_fall) |=> seq_reset);

  p_hold_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_reset) |-> ($past(cnt) == CNT_LAST));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (!busy && !seq_reset));

endmodule

// File: tb/msg_seg_ctrl_test.sv
module msg_seg_ctrl_test;
  localparam int SEG_W = 5;
  localparam int HOLD  = 3;
  localparam int NVEC  = 8;
  // {host_mode, host_sel, expected segment}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b0, 5'd0,  5'd0},
    {1'b0, 5'd9,  5'd1},
    {1'b0, 5'd0,  5'd2},
    {1'b1, 5'd30, 5'd30},
    {1'b0, 5'd0,  5'd31},
    {1'b0, 5'd0,  5'd0},
    {1'b1, 5'd5,  5'd5},
    {1'b0, 5'd17, 5'd6}
  };

  logic             clk = 0;
  logic             rst_n = 0;
  logic             host_mode = 0;
  logic [SEG_W-1:0] host_sel = '0;
  logic             start = 0;
  logic             seq_a14 = 0;
  logic [SEG_W-1:0] seg_addr;
  logic             play_n, seq_reset, busy;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  msg_seg_ctrl #(.SEG_W(SEG_W), .HOLD(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .host_sel(host_sel),
    .start(start), .seq_a14(seq_a14), .seg_addr(seg_addr), .play_n(play_n),
    .seq_reset(seq_reset), .busy(busy));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_state(input string req);
    check(req, "seg_addr", seg_addr, 0);
    check(req, "play_n", play_n, 1);
    check(req, "seq_reset", seq_reset, 0);
    check(req, "busy", busy, 0);
  endtask

  task automatic run_msg(input logic hm, input logic [SEG_W-1:0] sel,
                         input int exp, input string req, input bit poke);
    int n;
    @(negedge clk) host_mode = hm; host_sel = sel; start = 1;
    @(negedge clk) start = 0;
    check("R8", "busy after trigger", busy, 1);
    check(req, "seg_addr", seg_addr, exp);
    check("R6", "play_n before pulse", play_n, 1);
    @(negedge clk) check("R6", "play_n pulse", play_n, 0);
    @(negedge clk) check("R6", "play_n after pulse", play_n, 1);
    check("R7", "seq_reset while running", seq_reset, 0);
    if (poke) begin
      host_mode = 1; host_sel = SEG_W'(exp + 13); start = 1;
      @(negedge clk) start = 0;
      for (int i = 0; i < 3; i++) begin
        check("R9", "seg_addr after busy trigger", seg_addr, exp);
        check("R9", "play_n after busy trigger", play_n, 1);
        @(negedge clk);
      end
    end else repeat (3) @(negedge clk);
    seq_a14 = 1;
    @(negedge clk) seq_a14 = 0;
    @(negedge clk) check("R7", "seq_reset after fall", seq_reset, 1);
    check("R8", "busy during stop", busy, 1);
    n = 0;
    while (seq_reset && n < 20) begin
      n++;
      @(negedge clk);
    end
    check("R7", "reset length", n, HOLD);
    check("R8", "busy after stop", busy, 0);
    check("R5", "seg_addr after stop", seg_addr, exp);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_state("R1");
    rst_n = 1;
    @(negedge clk) idle_state("R1");

    // R10: falling address bit while idle
    seq_a14 = 1;
    @(negedge clk) seq_a14 = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10", "seq_reset idle fall", seq_reset, 0);
      check("R10", "busy idle fall", busy, 0);
    end

    for (int v = 0; v < NVEC; v++) begin
      logic hm;
      int   e;
      hm = VEC[v][10];
      e  = int'(VEC[v][4:0]);
      run_msg(hm, VEC[v][9:5], e, hm ? "R4" : ((v > 0 && e == 0) ? "R3" : "R2"), 0);
    end

    // R9: trigger during playback ignored, count not advanced
    run_msg(0, 0, 7, "R2", 1);
    run_msg(0, 0, 8, "R9", 0);

    // R1: reset in the middle of a message
    @(negedge clk) host_mode = 1; host_sel = 5'd20; start = 1;
    @(negedge clk) start = 0;
    repeat (3) @(negedge clk);
    rst_n = 0;
    @(negedge clk) idle_state("R1");
    rst_n = 1;
    run_msg(0, 5'd11, 0, "R1", 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule